// File: doc/BRIEF.md
# Level Interrupt Controller with Latched Reset-Switch Event

This block gathers 32 interrupt sources into one CPU interrupt line and exposes them through three registers on a simple 32-bit register bus. Software reads a cause register, enables sources through a mask register, and treats the bitwise AND of the two as the pending set. Most cause bits follow their source inputs live, so a source stops being pending as soon as it drops its request. One bit is different. The reset-switch event is latched when the switch is pressed and stays set until software writes a 1 to clear it. The cause register also carries the live state of the switch, which is not an interrupt. A write to the reset-control register produces a one-cycle platform reset request.

The bus side uses a request/response pair. A request is accepted in the cycle where `req_valid_i` is high, because `req_ready_o` is held at 1 and the block never applies back-pressure. A read returns its data with `rsp_valid_o` exactly one cycle after it is accepted. The response cannot be stalled, so the requester must take it in that cycle. A write takes effect at the clock edge that accepts it. The switch input is asynchronous and passes through a synchronizer before it is used. Debouncing and priority vectoring are left to the rest of the system.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the mask register reads 0, `cpu_irq_o` is low, `plat_rst_req_o` is low, and the latched switch event is clear.
- R2: The cause register is at byte offset 0x00, the mask register at 0x04 and the reset-control register at 0x24. A read of any other offset returns 0, and a write to any other offset changes no state.
- R3: The mask register holds all 32 bits as written and reads back what was last written. Bit i set to 1 enables source i.
- R4: Every cause bit other than bits 1 and 16 equals the live value of `src_lvl_i` at that position. Writing 1 to such a bit leaves its read value unchanged. Inputs `src_lvl_i[1]` and `src_lvl_i[16]` are ignored.
- R5: Cause bit 1 is the latched switch event. It sets on the press edge of the synchronized switch, where a press is `rst_sw_n_i` = 0 held through a 2-stage synchronizer. Once set, it holds until a cause write with data bit 1 = 1 clears it. If a press edge and such a clear fall in the same cycle, the bit stays set.
- R6: Cause bit 16 reads the synchronized switch level: 0 while pressed and 1 while released. This bit never raises `cpu_irq_o`, even when mask bit 16 is set.
- R7: `cpu_irq_o` is a registered copy of the OR over (cause AND mask) with bit 16 excluded, so it lags the registers and source inputs by exactly one clock.
- R8: Any accepted write to offset 0x24 drives `plat_rst_req_o` high for exactly the one cycle after acceptance, whatever the data.
- R9: If the level sources are idle, writing 0 to the mask register and then all ones to the cause register leaves `cpu_irq_o` low and clears the latched switch event.
- R10: `req_ready_o` is always 1. Each accepted read produces exactly one `rsp_valid_o` pulse one cycle later, carrying the register value sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Bus request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata_o | output | 32 | Read data |
| src_lvl_i | input | 32 | Level-sensitive interrupt sources, active high |
| rst_sw_n_i | input | 1 | Reset switch, asynchronous, 0 = pressed |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| plat_rst_req_o | output | 1 | One-cycle platform reset request |

## Verification
The bench lines up a switch press edge with a write-1 clear in the same cycle. A design that gives the clear priority would lose that event and read bit 1 as 0. It sets source bits 1 and 16 and writes 1s across the level bits. This exposes a design that latches level bits or lets those two inputs leak into the cause register. It enables only mask bit 16 and expects no interrupt, which catches a design that forwards the switch state to the CPU. It also samples the interrupt and reset-request pins cycle by cycle. A design with an extra or a missing register stage, or a reset pulse longer than one cycle, would show up there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned OFF_CAUSE = 32'h00;
  localparam int unsigned OFF_MASK  = 32'h04;
  localparam int unsigned OFF_RESET = 32'h24;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_RESET = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    reg_sel_e sel;
    if (off == OFF_CAUSE)      sel = SEL_CAUSE;
    else if (off == OFF_MASK)  sel = SEL_MASK;
    else if (off == OFF_RESET) sel = SEL_RESET;
    else                       sel = SEL_NONE;
    return sel;
  endfunction

endpackage

// File: rtl/irqc_sw_sync.sv
module irqc_sw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_n_i,
  output logic sw_n_sync_o,
  output logic press_edge_o
);

  logic [STAGES-1:0] chain_q;
  logic              press_d_q;
  logic              press_w;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= sw_n_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], sw_n_i};
      end
    end
  endgenerate

  assign sw_n_sync_o = chain_q[STAGES-1];
  assign press_w     = ~chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) press_d_q <= 1'b0;
    else        press_d_q <= press_w;
  end

  assign press_edge_o = press_w & ~press_d_q;

  // R5: a press yields a single edge pulse, never two in a row
  a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    press_edge_o |=> !press_edge_o);

endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] cause_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              cause_wr_o,
  output logic              plat_rst_req_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  reg_sel_e          sel_w;
  logic              wr_fire_w;
  logic              rd_fire_w;
  logic [DATA_W-1:0] rd_mux_w;
  logic [DATA_W-1:0] mask_q;
  logic              rst_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign sel_w     = decode_offset(32'(req_addr_i));
  assign wr_fire_w = req_valid_i & req_write_i;
  assign rd_fire_w = req_valid_i & ~req_write_i;

  always_comb begin
    case (sel_w)
      SEL_CAUSE: rd_mux_w = cause_i;
      SEL_MASK:  rd_mux_w = mask_q;
      default:   rd_mux_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             mask_q <= '0;
    else if (wr_fire_w && sel_w == SEL_MASK) mask_q <= req_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= wr_fire_w && (sel_w == SEL_RESET);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_fire_w;
      if (rd_fire_w) rsp_data_q <= rd_mux_w;
    end
  end

  assign mask_o         = mask_q;
  assign cause_wr_o     = wr_fire_w && (sel_w == SEL_CAUSE);
  assign plat_rst_req_o = rst_q;
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_rdata_o    = rsp_data_q;

  // R3: mask only moves on a write
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && req_write_i) |=> $stable(mask_q));

  // R10: one response per accepted read
  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SW_BIT      = 1,
  parameter int unsigned STATE_BIT   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NSRC-1:0]   req_wdata_i,
  output logic              rsp_valid_o,
  output logic [NSRC-1:0]   rsp_rdata_o,
  input  logic [NSRC-1:0]   src_lvl_i,
  input  logic              rst_sw_n_i,
  output logic              cpu_irq_o,
  output logic              plat_rst_req_o
);

  localparam logic [NSRC-1:0] ONE        = {{(NSRC-1){1'b0}}, 1'b1};
  localparam logic [NSRC-1:0] SW_MASK    = ONE << SW_BIT;
  localparam logic [NSRC-1:0] STATE_MASK = ONE << STATE_BIT;
  localparam logic [NSRC-1:0] IRQ_ELIG   = ~STATE_MASK;
  localparam logic [NSRC-1:0] LVL_BITS   = ~(SW_MASK | STATE_MASK);

  logic [NSRC-1:0] cause_w;
  logic [NSRC-1:0] mask_w;
  logic            cause_wr_w;
  logic            sw_n_sync_w;
  logic            press_edge_w;
  logic            sw_evt_w;
  logic            irq_q;
  logic            unused_src;

  assign req_ready_o = 1'b1;
  assign unused_src  = src_lvl_i[SW_BIT] ^ src_lvl_i[STATE_BIT];

  irqc_sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_n_i       (rst_sw_n_i),
    .sw_n_sync_o  (sw_n_sync_w),
    .press_edge_o (press_edge_w)
  );

  irqc_sticky u_sw_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (press_edge_w),
    .clr_i (cause_wr_w & req_wdata_i[SW_BIT]),
    .q_o   (sw_evt_w)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_cause
      if (i == SW_BIT) begin : g_evt
        assign cause_w[i] = sw_evt_w;
      end else if (i == STATE_BIT) begin : g_state
        assign cause_w[i] = sw_n_sync_w;
      end else begin : g_lvl
        assign cause_w[i] = src_lvl_i[i];
      end
    end
  endgenerate

  irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(NSRC)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_addr_i     (req_addr_i),
    .req_wdata_i    (req_wdata_i),
    .cause_i        (cause_w),
    .mask_o         (mask_w),
    .cause_wr_o     (cause_wr_w),
    .plat_rst_req_o (plat_rst_req_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_rdata_o    (rsp_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(cause_w & mask_w & IRQ_ELIG);
  end

  assign cpu_irq_o = irq_q;

  // R7: an enabled active level source raises the CPU line one clock later
  a_r7_level_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_lvl_i & mask_w & LVL_BITS)) |=> cpu_irq_o);

  // R6: the switch state bit alone never interrupts
  a_r6_state_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == STATE_MASK) |=> !cpu_irq_o);

  // R8: a reset request only follows a write
  a_r8_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst_req_o |-> $past(req_valid_i && req_write_i));

endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] src_lvl = '0;
  logic        sw_n = 1'b1;
  logic        cpu_irq;
  logic        plat_rst_req;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // model state
  logic [31:0] m_mask = '0;
  logic        m_evt  = 1'b0;

  always #5 clk = ~clk;

  irq_level_ctrl i_irq_level_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_write_i    (req_write),
    .req_addr_i     (req_addr),
    .req_wdata_i    (req_wdata),
    .rsp_valid_o    (rsp_valid),
    .rsp_rdata_o    (rsp_rdata),
    .src_lvl_i      (src_lvl),
    .rst_sw_n_i     (sw_n),
    .cpu_irq_o      (cpu_irq),
    .plat_rst_req_o (plat_rst_req)
  );

  function automatic logic [31:0] model_cause();
    logic [31:0] c;
    c = src_lvl & ~32'h0001_0002;
    c[1]  = m_evt;
    c[16] = sw_n;
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each read response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  // called at a negedge; returns at the following negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(cpu_irq === 1'b0, "R1 irq low after reset", {31'b0, cpu_irq}, 32'h0);
    check(plat_rst_req === 1'b0, "R1 reset req low", {31'b0, plat_rst_req}, 32'h0);
    bus_read(8'h04, 32'h0, "R1 mask zero after reset");
    bus_read(8'h00, 32'h0001_0000, "R1 cause idle, evt clear");
    // R10 ready
    check(req_ready === 1'b1, "R10 ready high", {31'b0, req_ready}, 32'h1);

    // R3 mask read/write
    bus_write(8'h04, 32'hA5A5_5A5A); m_mask = 32'hA5A5_5A5A;
    bus_read(8'h04, m_mask, "R3 mask readback A5A5");
    bus_write(8'h04, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;
    bus_read(8'h04, m_mask, "R3 mask readback all ones");

    // R2 unmapped offsets
    bus_read(8'h08, 32'h0, "R2 unmapped read zero");
    bus_read(8'h24, 32'h0, "R2 reset reg reads zero");
    bus_write(8'h10, 32'h0);
    bus_read(8'h04, m_mask, "R2 unmapped write leaves mask");

    // R4 live levels, ignored special inputs
    bus_write(8'h04, 32'h0); m_mask = '0;
    src_lvl = 32'hDEAD_BEEF;
    bus_read(8'h00, model_cause(), "R4 cause tracks sources");
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, model_cause(), "R4 write-1 no effect on levels");
    src_lvl = 32'h0000_0100;
    bus_read(8'h00, model_cause(), "R4 cause follows deassert");

    // R7 irq path and latency
    idle(2);
    check(cpu_irq === 1'b0, "R7 masked source no irq", {31'b0, cpu_irq}, 32'h0);
    bus_write(8'h04, 32'h0000_0100); m_mask = 32'h100;
    idle(1);
    check(cpu_irq === 1'b1, "R7 enabled source irq", {31'b0, cpu_irq}, 32'h1);
    src_lvl = 32'h0;
    #1;
    check(cpu_irq === 1'b1, "R7 irq still high same cycle", {31'b0, cpu_irq}, 32'h1);
    @(negedge clk);
    check(cpu_irq === 1'b0, "R7 irq drops one clock later", {31'b0, cpu_irq}, 32'h0);

    // R6 state bit never interrupts
    bus_write(8'h04, 32'h0001_0000); m_mask = 32'h0001_0000;
    idle(3);
    check(cpu_irq === 1'b0, "R6 state bit masked-in no irq", {31'b0, cpu_irq}, 32'h0);
    sw_n = 1'b0;
    idle(5); m_evt = 1'b1;
    bus_read(8'h00, model_cause(), "R6 state bit 0 while pressed");
    check(cpu_irq === 1'b0, "R6 press w/o evt mask no irq", {31'b0, cpu_irq}, 32'h0);

    // R5 sticky event
    bus_write(8'h04, 32'h0000_0002); m_mask = 32'h2;
    idle(1);
    check(cpu_irq === 1'b1, "R5 latched evt irq", {31'b0, cpu_irq}, 32'h1);
    sw_n = 1'b1;
    idle(5);
    bus_read(8'h00, model_cause(), "R5 evt holds after release");
    bus_write(8'h00, 32'hFFFF_FFFD);
    bus_read(8'h00, model_cause(), "R5 write 0 to bit1 keeps evt");
    bus_write(8'h00, 32'h0000_0002); m_evt = 1'b0;
    bus_read(8'h00, model_cause(), "R5 write 1 clears evt");
    idle(1);
    check(cpu_irq === 1'b0, "R5 irq low after clear", {31'b0, cpu_irq}, 32'h0);

    // R5 set wins over clear in the same cycle
    sw_n = 1'b0;
    idle(2);
    bus_write(8'h00, 32'h0000_0002); m_evt = 1'b1;
    bus_read(8'h00, model_cause(), "R5 set beats clear");
    bus_write(8'h00, 32'h0000_0002); m_evt = 1'b0;
    bus_read(8'h00, model_cause(), "R5 held press no re-set");
    sw_n = 1'b1;
    idle(4);

    // R8 reset pulse
    check(plat_rst_req === 1'b0, "R8 idle before write", {31'b0, plat_rst_req}, 32'h0);
    bus_write(8'h24, 32'h0);
    check(plat_rst_req === 1'b1, "R8 pulse after write", {31'b0, plat_rst_req}, 32'h1);
    @(negedge clk);
    check(plat_rst_req === 1'b0, "R8 pulse one cycle", {31'b0, plat_rst_req}, 32'h0);
    bus_write(8'h24, 32'hFFFF_FFFF);
    check(plat_rst_req === 1'b1, "R8 pulse any data", {31'b0, plat_rst_req}, 32'h1);
    bus_read(8'h04, m_mask, "R8 reset write leaves mask");

    // R9 quiesce
    bus_write(8'h04, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;
    sw_n = 1'b0;
    idle(5); m_evt = 1'b1;
    sw_n = 1'b1;
    idle(4);
    check(cpu_irq === 1'b1, "R9 irq before quiesce", {31'b0, cpu_irq}, 32'h1);
    bus_write(8'h04, 32'h0); m_mask = '0;
    bus_write(8'h00, 32'hFFFF_FFFF); m_evt = 1'b0;
    idle(2);
    check(cpu_irq === 1'b0, "R9 irq low after quiesce", {31'b0, cpu_irq}, 32'h0);
    bus_read(8'h00, model_cause(), "R9 cause clean after quiesce");

    idle(3);
    check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule